// File: doc/BRIEF.md
# Planar Frame Buffer Write/Read Datapath

This block sits between a byte-wide processor port and a planar colour frame buffer built from several byte-wide memory planes, four by default. It converts one processor write into one byte per plane and folds the planes' bytes back into one byte on a processor read. Addressing, memory arbitration and display refresh are handled outside the block. The processor sees only a byte of write data or read data, and the memory presents every plane's byte at the addressed location.

Control state lives in a small indexed register bank. The processor first writes an index through the index port, then writes a value through the data port. The block keeps one latch per plane, and every memory read reloads all of them.

A write starts from the processor byte and can rotate it, substitute a fixed colour for it, or spread it across the planes as a colour. The result is combined with the latches by a selectable logic function and merged with the latches under a bit mask. A per-plane enable input then decides which planes store the result. A read returns either one selected plane or a byte that flags which pixel positions match a colour.

Top module: `plane_rw_path`

## Requirements
- R1: A register write with `reg_sel_data`=0 stores the byte as the index. A write with `reg_sel_data`=1 stores it into the indexed register: 0 fixed colour, 1 fixed-colour enable, 2 compare colour, 3 rotate/function, 4 read plane select, 5 mode, 7 compare care, 8 bit mask. Index 6 and any index above 8 change nothing, and bits outside the defined fields have no effect. After reset every register is zero except the bit mask, which is all ones.
- R2: Every memory read loads each plane latch with that plane's byte from `plane_rdata`, in either read mode. With no read, the latches hold their value.
- R3: In write modes 0 and 3, the processor byte is rotated right by the count in register 3 bits 2:0.
- R4: Register 3 bits 4:3 select how the source byte is combined with the plane latch in write modes 0, 2 and 3: 00 passes it unchanged, 01 ANDs it, 10 ORs it and 11 XORs it.
- R5: In write mode 0, a plane whose bit in register 1 is 1 takes all ones or all zeros, following its bit in register 0, instead of the rotated byte. Modes 2 and 3 ignore registers 0 and 1.
- R6: In write modes 0, 2 and 3, each bit position whose mask bit is 0 takes the latch bit instead of the computed bit. The mask is register 8, further ANDed with the rotated byte in mode 3.
- R7: Write mode 1 (register 5 bits 1:0 = 01) writes each latch unchanged to its plane and ignores rotation, logic function and bit mask.
- R8: In write mode 2, plane p's source byte is all ones when processor bit p is 1 and all zeros otherwise, with no rotation applied.
- R9: In write mode 3, the rotated processor byte is the source and the effective bit mask is register 8 ANDed with the rotated byte.
- R10: During a memory write, `plane_we` equals `plane_wen` (bit n enables plane n). At all other times `plane_we` is zero.
- R11: In read mode 0 (register 5 bit 3 = 0), a memory read returns the plane numbered by register 4 bits 1:0. `cpu_rdata` is zero when no read is in progress.
- R12: In read mode 1, result bit i is 1 when, for every plane p whose bit in register 7 is 1, plane p's bit i equals bit p of register 2. When register 7 is zero, every result bit is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register port write strobe |
| reg_sel_data | input | 1 | 0 selects the index port, 1 selects the data port |
| reg_wdata | input | DW | Register port write byte |
| mem_wr | input | 1 | Processor memory write in progress |
| mem_rd | input | 1 | Processor memory read in progress |
| cpu_wdata | input | DW | Processor write byte |
| plane_wen | input | NP | Per-plane write enable mask |
| plane_rdata | input | NP*DW | Bytes of all planes at the addressed location, plane p at bits p*DW upward |
| plane_we | output | NP | Per-plane write strobes |
| plane_wdata | output | NP*DW | Byte to store in each plane |
| cpu_rdata | output | DW | Processor read byte |

## Verification
The assertions assume that `plane_rdata` is valid whenever `mem_rd` is high, and that `mem_rd` and `mem_wr` are never high in the same cycle. They also assume that the read plane select names an existing plane. The plane-select check only applies when the select is below the plane count. The stimulus drives one access at a time on the falling edge and presents memory bytes together with the read strobe. It writes register fields only within their defined widths, except for the one test that deliberately sets undefined bits.

// File: rtl/plane_rw_pkg.sv
package plane_rw_pkg;

   typedef enum logic [1:0] {
      WM_ROTATED = 2'd0,
      WM_LATCHED = 2'd1,
      WM_COLOR   = 2'd2,
      WM_MASKED  = 2'd3
   } wmode_e;

   typedef enum logic [1:0] {
      LF_PASS = 2'd0,
      LF_AND  = 2'd1,
      LF_OR   = 2'd2,
      LF_XOR  = 2'd3
   } lfunc_e;

   localparam int unsigned IX_SETRST = 0;
   localparam int unsigned IX_SREN   = 1;
   localparam int unsigned IX_CCMP   = 2;
   localparam int unsigned IX_ROTFN  = 3;
   localparam int unsigned IX_RMAP   = 4;
   localparam int unsigned IX_MODE   = 5;
   localparam int unsigned IX_HOLE   = 6;
   localparam int unsigned IX_DCARE  = 7;
   localparam int unsigned IX_BMASK  = 8;

endpackage

// File: rtl/prw_regbank.sv
module prw_regbank
   import plane_rw_pkg::*;
#(
   parameter int unsigned DW = 8,
   parameter int unsigned NP = 4,
   parameter int unsigned RW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_we,
   input  logic          reg_sel_data,
   input  logic [DW-1:0] reg_wdata,
   output logic [NP-1:0] sr_o,
   output logic [NP-1:0] sren_o,
   output logic [NP-1:0] ccmp_o,
   output logic [NP-1:0] dcare_o,
   output logic [RW-1:0] rot_o,
   output lfunc_e        fn_o,
   output logic [1:0]    rmap_o,
   output wmode_e        wmode_o,
   output logic          rmode_o,
   output logic [DW-1:0] bmask_o
);

   logic [DW-1:0] idx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx     <= '0;
         sr_o    <= '0;
         sren_o  <= '0;
         ccmp_o  <= '0;
         dcare_o <= '0;
         rot_o   <= '0;
         fn_o    <= LF_PASS;
         rmap_o  <= '0;
         wmode_o <= WM_ROTATED;
         rmode_o <= 1'b0;
         bmask_o <= '1;
      end else if (reg_we) begin
         if (!reg_sel_data) begin
            idx <= reg_wdata;
         end else begin
            case (idx)
               DW'(IX_SETRST): sr_o    <= reg_wdata[NP-1:0];
               DW'(IX_SREN):   sren_o  <= reg_wdata[NP-1:0];
               DW'(IX_CCMP):   ccmp_o  <= reg_wdata[NP-1:0];
               DW'(IX_ROTFN): begin
                  rot_o <= reg_wdata[RW-1:0];
                  fn_o  <= lfunc_e'(reg_wdata[RW+1:RW]);
               end
               DW'(IX_RMAP):   rmap_o  <= reg_wdata[1:0];
               DW'(IX_MODE): begin
                  wmode_o <= wmode_e'(reg_wdata[1:0]);
                  rmode_o <= reg_wdata[3];
               end
               DW'(IX_DCARE):  dcare_o <= reg_wdata[NP-1:0];
               DW'(IX_BMASK):  bmask_o <= reg_wdata;
               default: ;
            endcase
         end
      end
   end

   // R1
   bmask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_sel_data && idx == DW'(IX_BMASK)) |=> bmask_o == $past(reg_wdata));

   // R1
   stray_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_sel_data && (idx == DW'(IX_HOLE) || idx > DW'(IX_BMASK)))
      |=> ($stable(bmask_o) && $stable(wmode_o) && $stable(rmode_o) && $stable(sr_o)
           && $stable(sren_o) && $stable(rot_o) && $stable(fn_o) && $stable(dcare_o)));

endmodule

// File: rtl/prw_latchbank.sv
module prw_latchbank #(
   parameter int unsigned DW = 8,
   parameter int unsigned NP = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [NP*DW-1:0] d_i,
   output logic [NP*DW-1:0] q_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q_o <= '0;
      else if (load_i)
         q_o <= d_i;
   end

   // R2
   latch_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> q_o == $past(d_i));

   // R2
   latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !load_i |=> $stable(q_o));

endmodule

// File: rtl/prw_writepath.sv
module prw_writepath
   import plane_rw_pkg::*;
#(
   parameter int unsigned DW = 8,
   parameter int unsigned NP = 4,
   parameter int unsigned RW = 3
) (
   input  logic [DW-1:0]    cpu_wdata_i,
   input  logic [NP*DW-1:0] latch_i,
   input  logic [NP-1:0]    sr_i,
   input  logic [NP-1:0]    sren_i,
   input  logic [RW-1:0]    rot_i,
   input  lfunc_e           fn_i,
   input  wmode_e           wmode_i,
   input  logic [DW-1:0]    bmask_i,
   output logic [NP*DW-1:0] wdata_o
);

   logic [2*DW-1:0] dbl;
   logic [DW-1:0]   rot_data;
   logic [DW-1:0]   eff_mask;

   assign dbl      = {cpu_wdata_i, cpu_wdata_i} >> rot_i;
   assign rot_data = dbl[DW-1:0];
   assign eff_mask = (wmode_i == WM_MASKED) ? (bmask_i & rot_data) : bmask_i;

   for (genvar p = 0; p < NP; p++) begin : g_plane
      logic [DW-1:0] lat;
      logic [DW-1:0] src;
      logic [DW-1:0] res;

      assign lat = latch_i[p*DW +: DW];

      always_comb begin
         case (wmode_i)
            WM_COLOR:   src = {DW{cpu_wdata_i[p]}};
            WM_ROTATED: src = sren_i[p] ? {DW{sr_i[p]}} : rot_data;
            default:    src = rot_data;
         endcase
         case (fn_i)
            LF_AND:  res = src & lat;
            LF_OR:   res = src | lat;
            LF_XOR:  res = src ^ lat;
            default: res = src;
         endcase
      end

      assign wdata_o[p*DW +: DW] = (wmode_i == WM_LATCHED) ? lat
                                 : ((res & eff_mask) | (lat & ~eff_mask));
   end

endmodule

// File: rtl/prw_readpath.sv
module prw_readpath #(
   parameter int unsigned DW = 8,
   parameter int unsigned NP = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rd_i,
   input  logic [NP*DW-1:0] plane_i,
   input  logic             rmode_i,
   input  logic [1:0]       rmap_i,
   input  logic [NP-1:0]    ccmp_i,
   input  logic [NP-1:0]    dcare_i,
   output logic [DW-1:0]    rdata_o
);

   logic [DW-1:0] sel;
   logic [DW-1:0] cmp;

   always_comb begin
      sel = '0;
      for (int p = 0; p < NP; p++) begin
         if (rmap_i == 2'(p))
            sel = plane_i[p*DW +: DW];
      end
      for (int i = 0; i < DW; i++) begin
         cmp[i] = 1'b1;
         for (int p = 0; p < NP; p++) begin
            if (dcare_i[p] && (plane_i[p*DW + i] != ccmp_i[p]))
               cmp[i] = 1'b0;
         end
      end
   end

   assign rdata_o = !rd_i ? '0 : (rmode_i ? cmp : sel);

   // R12
   no_care_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_i && rmode_i && dcare_i == '0) |-> rdata_o == '1);

   // R11
   idle_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_i |-> rdata_o == '0);

endmodule

// File: rtl/plane_rw_path.sv
module plane_rw_path
   import plane_rw_pkg::*;
#(
   parameter int unsigned DW = 8,
   parameter int unsigned NP = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_we,
   input  logic             reg_sel_data,
   input  logic [DW-1:0]    reg_wdata,
   input  logic             mem_wr,
   input  logic             mem_rd,
   input  logic [DW-1:0]    cpu_wdata,
   input  logic [NP-1:0]    plane_wen,
   input  logic [NP*DW-1:0] plane_rdata,
   output logic [NP-1:0]    plane_we,
   output logic [NP*DW-1:0] plane_wdata,
   output logic [DW-1:0]    cpu_rdata
);

   localparam int unsigned RW = $clog2(DW);

   if (DW < 8 || (DW & (DW - 1)) != 0) begin : g_bad_dw
      $error("plane_rw_path: DW must be a power of two of at least 8");
   end
   if (NP < 1 || NP > 4) begin : g_bad_np
      $error("plane_rw_path: NP must lie between 1 and 4");
   end

   logic [NP-1:0]    sr, sren, ccmp, dcare;
   logic [RW-1:0]    rot;
   lfunc_e           fn;
   logic [1:0]       rmap;
   wmode_e           wmode;
   logic             rmode;
   logic [DW-1:0]    bmask;
   logic [NP*DW-1:0] latch_q;

   prw_regbank #(.DW(DW), .NP(NP), .RW(RW)) u_regs (
      .clk, .rst_n, .reg_we, .reg_sel_data, .reg_wdata,
      .sr_o(sr), .sren_o(sren), .ccmp_o(ccmp), .dcare_o(dcare),
      .rot_o(rot), .fn_o(fn), .rmap_o(rmap), .wmode_o(wmode),
      .rmode_o(rmode), .bmask_o(bmask)
   );

   prw_latchbank #(.DW(DW), .NP(NP)) u_latch (
      .clk, .rst_n, .load_i(mem_rd), .d_i(plane_rdata), .q_o(latch_q)
   );

   prw_writepath #(.DW(DW), .NP(NP), .RW(RW)) u_wr (
      .cpu_wdata_i(cpu_wdata), .latch_i(latch_q), .sr_i(sr), .sren_i(sren),
      .rot_i(rot), .fn_i(fn), .wmode_i(wmode), .bmask_i(bmask),
      .wdata_o(plane_wdata)
   );

   prw_readpath #(.DW(DW), .NP(NP)) u_rd (
      .clk, .rst_n, .rd_i(mem_rd), .plane_i(plane_rdata), .rmode_i(rmode),
      .rmap_i(rmap), .ccmp_i(ccmp), .dcare_i(dcare), .rdata_o(cpu_rdata)
   );

   assign plane_we = mem_wr ? plane_wen : '0;

   // R10
   we_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_wr |-> plane_we == '0);

   // R10
   we_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (plane_we & ~plane_wen) == '0);

   // R7
   latch_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr && wmode == WM_LATCHED) |-> plane_wdata == latch_q);

   // R6
   zero_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr && bmask == '0) |-> plane_wdata == latch_q);

   // R11
   read_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd && !rmode && 32'(rmap) < NP) |-> cpu_rdata == plane_rdata[32'(rmap)*DW +: DW]);

endmodule

// File: tb/sim_plane_rw_path.sv
module sim_plane_rw_path;

   localparam int DW = 8;
   localparam int NP = 4;
   localparam int NV = 14;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic             rst_n, reg_we, reg_sel_data, mem_wr, mem_rd;
   logic [DW-1:0]    reg_wdata, cpu_wdata, cpu_rdata;
   logic [NP-1:0]    plane_wen, plane_we;
   logic [NP*DW-1:0] plane_rdata, plane_wdata;

   plane_rw_path #(.DW(DW), .NP(NP)) u0 (.*);

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   typedef struct packed {
      logic [1:0]  mode;
      logic [1:0]  fn;
      logic [2:0]  rot;
      logic [3:0]  sren;
      logic [3:0]  sr;
      logic [7:0]  bmask;
      logic [7:0]  cpu;
      logic [3:0]  wen;
      logic [31:0] exp;
   } vec_t;

   // latches hold F0_0F_AA_55 (plane3..plane0) during the table
   localparam vec_t TBL [NV] = '{
      '{2'd0, 2'd0, 3'd0, 4'h0, 4'h0, 8'hFF, 8'h3C, 4'hF, 32'h3C3C3C3C}, // R3 plain
      '{2'd0, 2'd0, 3'd1, 4'h0, 4'h0, 8'hFF, 8'h81, 4'hF, 32'hC0C0C0C0}, // R3 rotate 1
      '{2'd0, 2'd0, 3'd4, 4'h0, 4'h0, 8'hFF, 8'h12, 4'hF, 32'h21212121}, // R3 rotate 4
      '{2'd0, 2'd2, 3'd0, 4'h0, 4'h0, 8'hFF, 8'h0F, 4'hF, 32'hFF0FAF5F}, // R4 OR
      '{2'd0, 2'd3, 3'd0, 4'h0, 4'h0, 8'hFF, 8'hFF, 4'hF, 32'h0FF055AA}, // R4 XOR
      '{2'd0, 2'd1, 3'd0, 4'h0, 4'h0, 8'hFF, 8'h0F, 4'hF, 32'h000F0A05}, // R4 AND
      '{2'd0, 2'd0, 3'd0, 4'h5, 4'h1, 8'hFF, 8'h3C, 4'hF, 32'h3C003CFF}, // R5
      '{2'd0, 2'd0, 3'd0, 4'h0, 4'h0, 8'h0F, 8'h00, 4'hF, 32'hF000A050}, // R6
      '{2'd1, 2'd3, 3'd3, 4'h0, 4'h0, 8'h00, 8'h12, 4'hF, 32'hF00FAA55}, // R7
      '{2'd2, 2'd0, 3'd5, 4'hF, 4'h0, 8'hFF, 8'h05, 4'hF, 32'h00FF00FF}, // R8
      '{2'd2, 2'd0, 3'd0, 4'h0, 4'h0, 8'hF0, 8'h0A, 4'hF, 32'hF00FFA05}, // R8 masked
      '{2'd3, 2'd0, 3'd0, 4'hF, 4'hF, 8'h3C, 8'h0F, 4'hF, 32'hFC0FAE5D}, // R9
      '{2'd3, 2'd0, 3'd4, 4'h0, 4'h0, 8'hFF, 8'hF0, 4'hF, 32'hFF0FAF5F}, // R9 rotate 4
      '{2'd0, 2'd0, 3'd0, 4'h0, 4'h0, 8'hFF, 8'h3C, 4'hA, 32'h3C3C3C3C}  // R10
   };

   string tags [NV] = '{"R3", "R3", "R3", "R4", "R4", "R4", "R5", "R6",
                        "R7", "R8", "R8", "R9", "R9", "R10"};

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic wreg(input logic [7:0] ix, input logic [7:0] v);
      @(negedge clk); reg_we = 1'b1; reg_sel_data = 1'b0; reg_wdata = ix;
      @(negedge clk); reg_sel_data = 1'b1; reg_wdata = v;
      @(negedge clk); reg_we = 1'b0; reg_sel_data = 1'b0;
   endtask

   task automatic do_read(input logic [31:0] pd, output logic [7:0] r);
      @(negedge clk); mem_rd = 1'b1; plane_rdata = pd;
      #1 r = cpu_rdata;
      @(negedge clk); mem_rd = 1'b0;
   endtask

   task automatic do_write(input logic [7:0] d, input logic [3:0] wen,
                           output logic [31:0] wd, output logic [3:0] we);
      @(negedge clk); mem_wr = 1'b1; cpu_wdata = d; plane_wen = wen;
      #1 wd = plane_wdata; we = plane_we;
      @(negedge clk); mem_wr = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog R1 act=hung exp=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [31:0] wd;
      logic [3:0]  we;
      logic [7:0]  rd;
      rst_n = 1'b0; reg_we = 1'b0; reg_sel_data = 1'b0; reg_wdata = '0;
      mem_wr = 1'b0; mem_rd = 1'b0; cpu_wdata = '0; plane_wen = '0; plane_rdata = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk("R10 idle strobes", {28'd0, plane_we}, 32'h0);
      chk("R11 idle read byte", {24'd0, cpu_rdata}, 32'h0);

      // R1 reset state: mode 0, pass, no rotate, bit mask all ones
      do_write(8'hA5, 4'hF, wd, we);
      chk("R1 reset write", wd, 32'hA5A5A5A5);
      do_read(32'h44332211, rd);
      chk("R1 reset read plane 0", {24'd0, rd}, 32'h11);

      do_read(32'hF00FAA55, rd);
      chk("R11 plane 0", {24'd0, rd}, 32'h55);

      for (int k = 0; k < NV; k++) begin
         wreg(8'd3, {3'b000, TBL[k].fn, TBL[k].rot});
         wreg(8'd5, {6'b0, TBL[k].mode});
         wreg(8'd1, {4'h0, TBL[k].sren});
         wreg(8'd0, {4'h0, TBL[k].sr});
         wreg(8'd8, TBL[k].bmask);
         do_write(TBL[k].cpu, TBL[k].wen, wd, we);
         chk(tags[k], wd, TBL[k].exp);
         chk("R10 strobes", {28'd0, we}, {28'd0, TBL[k].wen});
      end

      // R1 unmapped indices and undefined bits
      wreg(8'd3, 8'h00); wreg(8'd5, 8'h00); wreg(8'd1, 8'h00); wreg(8'd8, 8'hFF);
      wreg(8'd6, 8'h03);
      wreg(8'd9, 8'h00);
      wreg(8'h88, 8'h1F);
      do_write(8'h3C, 4'hF, wd, we);
      chk("R1 unmapped index", wd, 32'h3C3C3C3C);
      wreg(8'd5, 8'hF4);
      wreg(8'd4, 8'hFC);
      do_write(8'h3C, 4'hF, wd, we);
      chk("R1 undefined mode bits", wd, 32'h3C3C3C3C);
      do_read(32'h44332211, rd);
      chk("R1 undefined select bits", {24'd0, rd}, 32'h11);

      // R11 plane select
      wreg(8'd4, 8'h02);
      do_read(32'h44332211, rd);
      chk("R11 plane 2", {24'd0, rd}, 32'h33);
      wreg(8'd4, 8'h03);
      do_read(32'h44332211, rd);
      chk("R11 plane 3", {24'd0, rd}, 32'h44);

      // R2 latches load in compare mode and then hold
      wreg(8'd5, 8'h08);
      do_read(32'h12345678, rd);
      wreg(8'd5, 8'h01);
      do_write(8'h00, 4'hF, wd, we);
      chk("R2 load in compare read", wd, 32'h12345678);
      wreg(8'd3, 8'h1D);
      do_write(8'hFF, 4'hF, wd, we);
      chk("R2 hold without read", wd, 32'h12345678);

      // R12 colour compare
      wreg(8'd5, 8'h08);
      wreg(8'd2, 8'h03);
      wreg(8'd7, 8'h07);
      do_read({8'h00, 8'hAA, 8'hCC, 8'hF0}, rd);
      chk("R12 three planes", {24'd0, rd}, 32'h40);
      wreg(8'd7, 8'h00);
      do_read({8'h00, 8'hAA, 8'hCC, 8'hF0}, rd);
      chk("R12 no planes cared", {24'd0, rd}, 32'hFF);
      wreg(8'd7, 8'h08);
      wreg(8'd2, 8'h00);
      do_read({8'h00, 8'hAA, 8'hCC, 8'hF0}, rd);
      chk("R12 plane 3 zero match", {24'd0, rd}, 32'hFF);
      wreg(8'd2, 8'h08);
      do_read({8'h00, 8'hAA, 8'hCC, 8'hF0}, rd);
      chk("R12 plane 3 no match", {24'd0, rd}, 32'h00);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule